// File: doc/BRIEF.md
# Rename Stage Stall Controller

This block is the control state machine of a register-rename pipeline stage for one thread. Each cycle it decides whether the stage passes an instruction through, blocks, drains its parked instructions, recovers from a squash, or holds a serializing instruction until the reorder buffer has emptied. It raises one-cycle block and unblock flags toward decode only when its state changes. While the stage cannot advance, incoming instructions are parked in a bounded circular skid buffer, and that buffer is replayed oldest first once the stall clears.

Downstream stages send separate stall and unstall pulses for the issue side and the commit side. The controller keeps one sticky bit for each side. Commit also supplies a squash pulse and a flag showing that the reorder buffer is still squashing. A single resource-exhausted input combines the credit checks (reorder buffer, issue queue, load/store queue and free physical registers). Two further inputs report that the reorder buffer is empty and that nothing is in flight between rename and dispatch. The datapath moves one instruction per cycle. The skid depth is 2 × (issue-to-rename delay × decode width) + rename width. The actual register mapping is outside this block.

Top module: `rn_stall_fsm`

## Requirements
- R1: After reset the state is Idle (code 0), the skid buffer is empty, and out_valid, out_from_skid, dec_block and dec_unblock are all 0. The state codes are Idle 0, Running 1, Blocked 2, Unblocking 3, Squashing 4 and SerializeStall 5.
- R2: In Idle or Running with no stall, a valid input with in_ser_before clear and no pending serialize mark appears on out_data one cycle later. out_valid is 1, out_from_skid is 0, and the state becomes Running.
- R3: Conditions are checked in fixed priority: a squash pulse first, then reorder-buffer-squashing, then any stall condition, then the Blocked, Squashing and SerializeStall exit transitions. A squash arriving together with a stall pulse therefore lands in Squashing with no block flag.
- R4: A stall condition is any of these: the issue sticky bit, the commit sticky bit, res_exhausted, or being in SerializeStall while rob_empty and none_inflight are not both 1. A stall pulse sets its side's sticky bit and an unstall pulse clears it, both taking effect in the same cycle. During a stall a valid input is appended to the skid buffer and nothing is output.
- R5: A stall raises dec_block for one cycle only if the state is Idle, Running or Squashing. A stall never moves SerializeStall to Blocked.
- R6: Blocked with no stall condition moves to Unblocking, and a valid input in that cycle is appended to the skid buffer.
- R7: In Unblocking, one skid entry per cycle is output with out_from_skid = 1 and valid inputs are appended. When the buffer would be empty after that cycle, dec_unblock pulses and the state becomes Running.
- R8: A squash pulse empties the skid buffer and moves to Squashing. If the state was Blocked, Unblocking or SerializeStall, dec_unblock pulses. dec_block and dec_unblock never pulse together.
- R9: rob_squashing without a squash moves to Squashing and does not pulse dec_unblock. Squashing leaves for Running on the first cycle with no higher-priority condition. Inputs that arrive while in Squashing are discarded.
- R10: An instruction with in_ser_before set, arriving in Idle or Running, is held: the state becomes SerializeStall, dec_block pulses, and nothing is output. When the reorder buffer is empty and nothing is in flight, the state moves to Unblocking with the held instruction, its serialize mark cleared, at the head of the skid buffer. It is therefore output before the inputs that were parked behind it.
- R11: An instruction with in_ser_after set, once output, arms a pending mark. The next instruction is then treated as serialize-before. The pending mark is dropped if rob_empty and none_inflight are both 1 when that instruction is considered.
- R12: skid_count never exceeds 2 × IEW_DLY × DEC_W + REN_W (10 with the defaults). A buffer filled to exactly that depth drains in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction arrives from decode |
| in_data | input | DATA_W | Instruction tag |
| in_ser_before | input | 1 | Instruction must wait for an empty reorder buffer |
| in_ser_after | input | 1 | Next instruction must be serialized |
| iss_stall | input | 1 | Issue-side stall pulse |
| iss_unstall | input | 1 | Issue-side unstall pulse |
| cmt_stall | input | 1 | Commit-side stall pulse |
| cmt_unstall | input | 1 | Commit-side unstall pulse |
| cmt_squash | input | 1 | Squash pulse from commit |
| rob_squashing | input | 1 | Reorder buffer is still squashing |
| res_exhausted | input | 1 | Some downstream credit or the free register pool is exhausted |
| rob_empty | input | 1 | Reorder buffer holds no instructions |
| none_inflight | input | 1 | No renamed instruction awaits dispatch |
| state | output | 3 | Current state code |
| dec_block | output | 1 | One-cycle block flag to decode |
| dec_unblock | output | 1 | One-cycle unblock flag to decode |
| out_valid | output | 1 | An instruction is sent onward |
| out_data | output | DATA_W | Tag of the instruction sent (0 when none) |
| out_from_skid | output | 1 | The sent instruction came from the skid buffer |
| skid_count | output | $clog2(depth+1) | Entries held in the skid buffer |
| skid_head | output | DATA_W | Tag at the skid buffer head |

## Verification
The assertions assume several things about the inputs. An unstall pulse arrives only on a side whose sticky bit is set, or together with that side's stall pulse. Upstream never delivers more instructions than the skid depth while the stage is held. No serializing instruction arrives when the buffer is one entry short of full. The stimulus keeps to these rules by construction: every unstall follows its own stall, and the fill test stops at exactly the buffer depth. Both serializing cases are run with the reorder buffer first busy and then empty, and the squash cases clear the sticky stall bit in the squash cycle so that recovery is not masked.

// File: rtl/rn_stall_pkg.sv
package rn_stall_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_RUN    = 3'd1,
      ST_BLOCK  = 3'd2,
      ST_UNBLK  = 3'd3,
      ST_SQUASH = 3'd4,
      ST_SERIAL = 3'd5
   } rn_state_e;

   // stall sources held as sticky bits
   localparam int unsigned SRC_ISSUE  = 0;
   localparam int unsigned SRC_COMMIT = 1;
   localparam int unsigned N_SRC      = 2;

   function automatic int unsigned skid_cap(input int unsigned dly,
                                            input int unsigned dec_w,
                                            input int unsigned ren_w);
      return 2 * (dly * dec_w) + ren_w;
   endfunction

endpackage

// File: rtl/rn_sticky_stall.sv
module rn_sticky_stall #(
   parameter int unsigned N_SRC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] set_i,
   input  logic [N_SRC-1:0] clr_i,
   output logic [N_SRC-1:0] eff_o
);

   logic [N_SRC-1:0] held_q;

   if (N_SRC < 1) begin : g_bad_cfg
      $error("rn_sticky_stall: N_SRC must be at least 1");
   end

   // this cycle's pulses take effect at once; the register carries them on
   assign eff_o = set_i | (held_q & ~clr_i);

   always_ff @(posedge clk) begin
      if (!rst_n) held_q <= '0;
      else        held_q <= eff_o;
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      // R4: an unstall pulse only follows a stall on the same side
      assert_unstall_after_stall_R4: assert property (
         @(posedge clk) disable iff (!rst_n)
         clr_i[i] |-> (held_q[i] | set_i[i]));
   end

endmodule

// File: rtl/rn_skid_ring.sv
module rn_skid_ring #(
   parameter int unsigned ENT_W = 10,
   parameter int unsigned DEPTH = 10,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             pop_i,
   input  logic             push_tail_i,
   input  logic [ENT_W-1:0] tail_d_i,
   input  logic             push_head_i,
   input  logic [ENT_W-1:0] head_d_i,
   output logic [ENT_W-1:0] head_o,
   output logic [CNT_W-1:0] count_o
);

   localparam bit          POW2 = ((DEPTH & (DEPTH - 1)) == 0);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [ENT_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] head_q, tail_idx, inc_idx, dec_idx;
   logic [CNT_W-1:0] count_q;

   if (DEPTH < 2) begin : g_bad_cfg
      $error("rn_skid_ring: DEPTH must be at least 2");
   end

   if (POW2) begin : g_wrap_pow2
      assign tail_idx = PTR_W'(int'(head_q) + int'(count_q));
      assign inc_idx  = head_q + PTR_W'(1);
      assign dec_idx  = head_q - PTR_W'(1);
   end else begin : g_wrap_cmp
      always_comb begin
         int s;
         s = int'(head_q) + int'(count_q);
         tail_idx = (s >= int'(DEPTH)) ? PTR_W'(s - int'(DEPTH)) : PTR_W'(s);
         inc_idx  = (head_q == LAST) ? '0 : head_q + PTR_W'(1);
         dec_idx  = (head_q == '0) ? LAST : head_q - PTR_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         head_q  <= '0;
         count_q <= '0;
      end else begin
         head_q  <= pop_i ? inc_idx : (push_head_i ? dec_idx : head_q);
         count_q <= CNT_W'(int'(count_q) - int'(pop_i)
                           + int'(push_head_i) + int'(push_tail_i));
      end
   end

   always_ff @(posedge clk) begin
      if (!clr_i && push_tail_i) mem[tail_idx] <= tail_d_i;
      if (!clr_i && push_head_i) mem[dec_idx]  <= head_d_i;
   end

   assign head_o  = mem[head_q];
   assign count_o = count_q;

   assert_no_overflow_R12: assert property (
      @(posedge clk) disable iff (!rst_n)
      !clr_i |-> (int'(count_q) + int'(push_head_i) + int'(push_tail_i)
                  - int'(pop_i)) <= int'(DEPTH));

   assert_no_pop_empty_R7: assert property (
      @(posedge clk) disable iff (!rst_n)
      pop_i |-> (count_q != '0));

endmodule

// File: rtl/rn_stall_fsm.sv
module rn_stall_fsm
   import rn_stall_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned IEW_DLY = 2,
   parameter int unsigned DEC_W   = 2,
   parameter int unsigned REN_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_ser_before,
   input  logic              in_ser_after,
   input  logic              iss_stall,
   input  logic              iss_unstall,
   input  logic              cmt_stall,
   input  logic              cmt_unstall,
   input  logic              cmt_squash,
   input  logic              rob_squashing,
   input  logic              res_exhausted,
   input  logic              rob_empty,
   input  logic              none_inflight,
   output logic [2:0]        state,
   output logic              dec_block,
   output logic              dec_unblock,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_from_skid,
   output logic [$clog2(2*IEW_DLY*DEC_W+REN_W+1)-1:0] skid_count,
   output logic [DATA_W-1:0] skid_head
);

   localparam int unsigned SKID_DEPTH = skid_cap(IEW_DLY, DEC_W, REN_W);
   localparam int unsigned ENT_W      = DATA_W + 2;
   localparam int unsigned CNT_W      = $clog2(SKID_DEPTH + 1);
   localparam int unsigned SB_BIT     = DATA_W;      // serialize-before mark
   localparam int unsigned SA_BIT     = DATA_W + 1;  // serialize-after mark

   if (DATA_W < 1 || IEW_DLY < 1 || DEC_W < 1 || REN_W < 1) begin : g_bad_cfg
      $error("rn_stall_fsm: all size parameters must be at least 1");
   end

   rn_state_e        st, nxt_st;
   logic [ENT_W-1:0] hold_q, hold_n, in_ent, sk_head, f_hd;
   logic [CNT_W-1:0] sk_cnt;
   logic             pend_q, pend_n;
   logic [N_SRC-1:0] stl_set, stl_clr, stl_eff;
   logic             blk, unblk, ov, ofs;
   logic [DATA_W-1:0] od;
   logic             f_clr, f_pt, f_ph, f_pop;
   logic             drained, pend_eff, stall_any;

   assign stl_set[SRC_ISSUE]  = iss_stall;
   assign stl_set[SRC_COMMIT] = cmt_stall;
   assign stl_clr[SRC_ISSUE]  = iss_unstall;
   assign stl_clr[SRC_COMMIT] = cmt_unstall;

   rn_sticky_stall #(.N_SRC(N_SRC)) u_sticky (
      .clk(clk), .rst_n(rst_n), .set_i(stl_set), .clr_i(stl_clr), .eff_o(stl_eff));

   rn_skid_ring #(.ENT_W(ENT_W), .DEPTH(SKID_DEPTH)) u_skid (
      .clk(clk), .rst_n(rst_n), .clr_i(f_clr), .pop_i(f_pop),
      .push_tail_i(f_pt), .tail_d_i(in_ent),
      .push_head_i(f_ph), .head_d_i(f_hd),
      .head_o(sk_head), .count_o(sk_cnt));

   assign in_ent    = {in_ser_after, in_ser_before, in_data};
   assign drained   = rob_empty & none_inflight;
   assign pend_eff  = pend_q & ~drained;
   assign stall_any = (|stl_eff) | res_exhausted | ((st == ST_SERIAL) & ~drained);

   always_comb begin
      int rem;
      nxt_st = st;
      blk = 1'b0; unblk = 1'b0; ov = 1'b0; ofs = 1'b0; od = '0;
      f_clr = 1'b0; f_pt = 1'b0; f_ph = 1'b0; f_pop = 1'b0;
      f_hd = hold_q & ~(ENT_W'(1) << SB_BIT);
      hold_n = hold_q;
      pend_n = pend_q & ~drained;
      rem = 0;
      if (cmt_squash) begin
         if (st == ST_BLOCK || st == ST_UNBLK || st == ST_SERIAL) unblk = 1'b1;
         nxt_st = ST_SQUASH;
         f_clr  = 1'b1;
         pend_n = 1'b0;
      end else if (rob_squashing) begin
         nxt_st = ST_SQUASH;
      end else if (stall_any) begin
         f_pt = in_valid;
         if (st != ST_BLOCK && st != ST_UNBLK && st != ST_SERIAL) blk = 1'b1;
         if (st != ST_SERIAL) nxt_st = ST_BLOCK;
      end else if (st == ST_BLOCK) begin
         nxt_st = ST_UNBLK;
         f_pt   = in_valid;
      end else if (st == ST_SQUASH) begin
         nxt_st = ST_RUN;
      end else if (st == ST_SERIAL) begin
         nxt_st = ST_UNBLK;
         f_ph   = 1'b1;
         f_pt   = in_valid;
      end else if (st == ST_UNBLK) begin
         f_pt = in_valid;
         if (sk_cnt != '0) begin
            f_pop = 1'b1;
            if (sk_head[SB_BIT] | pend_eff) begin
               hold_n = sk_head;
               nxt_st = ST_SERIAL;
               pend_n = 1'b0;
            end else begin
               ov  = 1'b1;
               ofs = 1'b1;
               od  = sk_head[DATA_W-1:0];
               if (sk_head[SA_BIT]) pend_n = 1'b1;
            end
         end
         rem = int'(sk_cnt) - int'(f_pop) + int'(f_pt);
         if (nxt_st == ST_UNBLK && rem == 0) begin
            unblk  = 1'b1;
            nxt_st = ST_RUN;
         end
      end else if (in_valid) begin
         if (in_ser_before | pend_eff) begin
            hold_n = in_ent;
            nxt_st = ST_SERIAL;
            blk    = 1'b1;
            pend_n = 1'b0;
         end else begin
            ov     = 1'b1;
            od     = in_data;
            nxt_st = ST_RUN;
            if (in_ser_after) pend_n = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st            <= ST_IDLE;
         hold_q        <= '0;
         pend_q        <= 1'b0;
         dec_block     <= 1'b0;
         dec_unblock   <= 1'b0;
         out_valid     <= 1'b0;
         out_data      <= '0;
         out_from_skid <= 1'b0;
      end else begin
         st            <= nxt_st;
         hold_q        <= hold_n;
         pend_q        <= pend_n;
         dec_block     <= blk;
         dec_unblock   <= unblk;
         out_valid     <= ov;
         out_data      <= od;
         out_from_skid <= ofs;
      end
   end

   assign state      = st;
   assign skid_count = sk_cnt;
   assign skid_head  = sk_head[DATA_W-1:0];

   assert_serial_not_blocked_R5: assert property (
      @(posedge clk) disable iff (!rst_n)
      (st == ST_SERIAL) |=> (st != ST_BLOCK));

   assert_squash_clears_R8: assert property (
      @(posedge clk) disable iff (!rst_n)
      cmt_squash |=> (st == ST_SQUASH) && (skid_count == '0));

   assert_flags_exclusive_R8: assert property (
      @(posedge clk) disable iff (!rst_n)
      !(dec_block && dec_unblock));

   assert_rob_squash_quiet_R9: assert property (
      @(posedge clk) disable iff (!rst_n)
      (rob_squashing && !cmt_squash) |=> (st == ST_SQUASH) && !dec_unblock);

   assert_skid_output_source_R7: assert property (
      @(posedge clk) disable iff (!rst_n)
      out_from_skid |-> ($past(st) == ST_UNBLK) && out_valid);

endmodule

// File: tb/rn_stall_fsm_bench.sv
module rn_stall_fsm_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 0, in_ser_before = 0, in_ser_after = 0;
   logic [7:0] in_data = '0;
   logic       iss_stall = 0, iss_unstall = 0, cmt_stall = 0, cmt_unstall = 0;
   logic       cmt_squash = 0, rob_squashing = 0, res_exhausted = 0;
   logic       rob_empty = 1, none_inflight = 1;
   logic [2:0] state;
   logic       dec_block, dec_unblock, out_valid, out_from_skid;
   logic [7:0] out_data, skid_head;
   logic [3:0] skid_count;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 0;

   always #5 clk = ~clk;

   rn_stall_fsm u_rn_stall_fsm (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ser_before(in_ser_before), .in_ser_after(in_ser_after),
      .iss_stall(iss_stall), .iss_unstall(iss_unstall),
      .cmt_stall(cmt_stall), .cmt_unstall(cmt_unstall),
      .cmt_squash(cmt_squash), .rob_squashing(rob_squashing),
      .res_exhausted(res_exhausted), .rob_empty(rob_empty),
      .none_inflight(none_inflight), .state(state), .dec_block(dec_block),
      .dec_unblock(dec_unblock), .out_valid(out_valid), .out_data(out_data),
      .out_from_skid(out_from_skid), .skid_count(skid_count),
      .skid_head(skid_head));

   typedef struct packed {
      logic v; logic [7:0] d; logic sb, sa, ist, iun, rex;
      logic [2:0] est; logic eov; logic [7:0] eod; logic eblk, eunb;
      logic [3:0] ecnt; logic efs;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t TBL [NV] = '{
      '{1'b1, 8'd11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 8'd11, 1'b0, 1'b0, 4'd0, 1'b0},
      '{1'b1, 8'd12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 8'd12, 1'b0, 1'b0, 4'd0, 1'b0},
      '{1'b0, 8'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 8'd0,  1'b0, 1'b0, 4'd0, 1'b0},
      '{1'b1, 8'd13, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2, 1'b0, 8'd0,  1'b1, 1'b0, 4'd1, 1'b0},
      '{1'b1, 8'd14, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0, 8'd0,  1'b0, 1'b0, 4'd2, 1'b0},
      '{1'b1, 8'd15, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd3, 1'b0, 8'd0,  1'b0, 1'b0, 4'd3, 1'b0},
      '{1'b0, 8'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b1, 8'd13, 1'b0, 1'b0, 4'd2, 1'b1},
      '{1'b1, 8'd16, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b1, 8'd14, 1'b0, 1'b0, 4'd2, 1'b1},
      '{1'b0, 8'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b1, 8'd15, 1'b0, 1'b0, 4'd1, 1'b1},
      '{1'b0, 8'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 8'd16, 1'b0, 1'b1, 4'd0, 1'b1},
      '{1'b1, 8'd17, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0, 8'd0,  1'b1, 1'b0, 4'd1, 1'b0},
      '{1'b0, 8'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b0, 8'd0,  1'b0, 1'b0, 4'd1, 1'b0},
      '{1'b1, 8'd18, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b1, 8'd17, 1'b0, 1'b0, 4'd1, 1'b1},
      '{1'b0, 8'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 8'd18, 1'b0, 1'b1, 4'd0, 1'b1},
      '{1'b1, 8'd20, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 8'd20, 1'b0, 1'b0, 4'd0, 1'b0},
      '{1'b1, 8'd21, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 8'd21, 1'b0, 1'b0, 4'd0, 1'b0}
   };

   function automatic string row_req(input int i);
      case (i)
         0, 1, 2:        return "R2";
         3:              return "R4";
         4, 10:          return "R5";
         5, 11:          return "R6";
         6, 7, 8, 9, 12, 13: return "R7";
         default:        return "R11";
      endcase
   endfunction

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic expect_out(input string req, input int est, input int eov, input int eod,
                             input int eblk, input int eunb, input int ecnt, input int efs);
      chk(req, "state", int'(state), est);
      chk(req, "out_valid", int'(out_valid), eov);
      chk(req, "out_data", int'(out_data), eod);
      chk(req, "dec_block", int'(dec_block), eblk);
      chk(req, "dec_unblock", int'(dec_unblock), eunb);
      chk(req, "skid_count", int'(skid_count), ecnt);
      chk(req, "out_from_skid", int'(out_from_skid), efs);
   endtask

   task automatic drive(input logic v, input logic [7:0] d, input logic sb, input logic sa,
                        input logic ist, input logic iun, input logic cst, input logic cun,
                        input logic csq, input logic rsq, input logic rex,
                        input logic robe, input logic nif);
      in_valid = v; in_data = d; in_ser_before = sb; in_ser_after = sa;
      iss_stall = ist; iss_unstall = iun; cmt_stall = cst; cmt_unstall = cun;
      cmt_squash = csq; rob_squashing = rsq; res_exhausted = rex;
      rob_empty = robe; none_inflight = nif;
      @(posedge clk);
      @(negedge clk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      expect_out("R1", 0, 0, 0, 0, 0, 0, 0);

      // table walk: pass-through, block, unblock drain, serialize-after drop
      for (int i = 0; i < NV; i++) begin
         drive(TBL[i].v, TBL[i].d, TBL[i].sb, TBL[i].sa, TBL[i].ist, TBL[i].iun,
               0, 0, 0, 0, TBL[i].rex, 1, 1);
         expect_out(row_req(i), int'(TBL[i].est), int'(TBL[i].eov), int'(TBL[i].eod),
                    int'(TBL[i].eblk), int'(TBL[i].eunb), int'(TBL[i].ecnt), int'(TBL[i].efs));
      end

      // R10: serialize-before held until the reorder buffer drains
      drive(1, 8'd30, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      expect_out("R10", 5, 0, 0, 1, 0, 0, 0);
      drive(0, 8'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1);   // R5: stall keeps SerializeStall
      expect_out("R5", 5, 0, 0, 0, 0, 0, 0);
      drive(1, 8'd31, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      expect_out("R10", 5, 0, 0, 0, 0, 1, 0);
      drive(0, 8'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
      expect_out("R10", 3, 0, 0, 0, 0, 2, 0);
      chk("R10", "skid_head", int'(skid_head), 30);
      drive(0, 8'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
      expect_out("R10", 3, 1, 30, 0, 0, 1, 1);
      drive(0, 8'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
      expect_out("R10", 1, 1, 31, 0, 1, 0, 1);

      // R11: serialize-after marks the next instruction while the ROB is busy
      drive(1, 8'd40, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      expect_out("R11", 1, 1, 40, 0, 0, 0, 0);
      drive(1, 8'd41, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      expect_out("R11", 5, 0, 0, 1, 0, 0, 0);
      drive(0, 8'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
      expect_out("R11", 3, 0, 0, 0, 0, 1, 0);
      drive(0, 8'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
      expect_out("R11", 1, 1, 41, 0, 1, 0, 1);

      // R8: squash from Blocked
      drive(1, 8'd50, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1, 1);
      expect_out("R8", 2, 0, 0, 1, 0, 1, 0);
      drive(1, 8'd51, 0, 0, 0, 1, 0, 0, 1, 0, 0, 1, 1);
      expect_out("R8", 4, 0, 0, 0, 1, 0, 0);
      drive(1, 8'd52, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
      expect_out("R9", 1, 0, 0, 0, 0, 0, 0);
      drive(1, 8'd53, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
      expect_out("R8", 1, 1, 53, 0, 0, 0, 0);

      // R9: reorder buffer still squashing
      drive(1, 8'd60, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 1);
      expect_out("R9", 4, 0, 0, 0, 0, 0, 0);
      drive(0, 8'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
      expect_out("R9", 1, 0, 0, 0, 0, 0, 0);

      // R3: squash beats a simultaneous commit stall
      drive(1, 8'd65, 0, 0, 0, 0, 1, 0, 1, 0, 0, 1, 1);
      expect_out("R3", 4, 0, 0, 0, 0, 0, 0);
      drive(0, 8'd0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1, 1);
      expect_out("R3", 1, 0, 0, 0, 0, 0, 0);

      // R12: fill the skid buffer to its depth and drain in order
      drive(1, 8'd70, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1, 1);
      expect_out("R12", 2, 0, 0, 1, 0, 1, 0);
      for (int k = 1; k < 10; k++) begin
         drive(1, 8'(70 + k), 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
      end
      expect_out("R12", 2, 0, 0, 0, 0, 10, 0);
      chk("R12", "skid_head", int'(skid_head), 70);
      drive(0, 8'd0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 1);
      expect_out("R12", 3, 0, 0, 0, 0, 10, 0);
      for (int k = 0; k < 10; k++) begin
         drive(0, 8'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
         chk("R12", "drain data", int'(out_data), 70 + k);
         chk("R12", "drain count", int'(skid_count), 9 - k);
      end
      chk("R7", "final unblock", int'(dec_unblock), 1);
      chk("R7", "final state", int'(state), 1);

      done = 1;
      summary();
      $finish;
   end

endmodule